// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block is the purely combinational control unit of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). From the instruction classes and register identifiers held in the decode, execute and memory pipeline registers, the branch-condition result of the execute stage and the status codes of the memory stage and the write-back register, it decides in every cycle which pipeline registers hold their contents (stall), which are overwritten with a no-op (bubble), and whether the condition codes may be written.

It handles four situations: a value loaded from memory that the next instruction needs, a subroutine return whose target is not known until write-back, a conditional branch that was predicted taken but falls through, and an instruction that raised an exception. Only two of these can arise in the same cycle. A mispredicted branch with a return behind it in decode, and a load/use conflict with a return in decode. Both are resolved here. A bubble loads a no-op class with normal status, so an instruction that is cancelled also loses its exception status. All pins are plain level signals. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Instruction class encoding (3 bits): 0 no-op, 1 ALU operation, 2 load (any class that writes a register from memory), 3 return, 4 conditional branch, 5 store, 6 other. Status encoding (2 bits): 0 normal, 1 halt, 2 bad address, 3 illegal instruction. The register identifier with all bits set means "no register".

Top module: `hzd_ctrl`

## Requirements
- R1: When the execute class is load (2) and its destination is not the all-ones "no register" code and equals either decode source, the outputs are f_stall=1, d_stall=1, e_bubble=1, with d_bubble=0.
- R2: A load whose destination is the all-ones code, or matches neither decode source, and a non-load class in execute with a matching destination, create no stall and no bubble.
- R3: When a return (class 3) is in decode, execute or memory and no load/use conflict exists, f_stall=1 and d_bubble=1, while e_bubble=0 and d_stall=0.
- R4: A conditional branch (class 4) in execute with the condition false gives d_bubble=1 and e_bubble=1. With the condition true there is no action.
- R5: A mispredicted branch with a return in decode gives d_bubble=1 and e_bubble=1, with d_stall=0. The return is cancelled rather than held.
- R6: A load/use conflict with a return in decode gives f_stall=1, d_stall=1, e_bubble=1 and d_bubble=0.
- R7: m_bubble is 1 exactly when the memory-stage status or the write-back status is not normal (non-zero).
- R8: w_stall is 1 exactly when the write-back status is not normal. A fault only in the memory stage does not stall write-back.
- R9: cc_write_en is 1 only when the execute class is ALU (1) and both memory-stage and write-back statuses are normal (0).
- R10: Stall and bubble of the decode register are never asserted together, and no output is active when all inputs are idle (all zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_op | input | 3 | Instruction class in the decode register |
| dec_srcs | input | NUM_SRC*REG_W | Decode source register IDs, source 0 in the low bits |
| exe_op | input | 3 | Instruction class in the execute register |
| exe_ld_dst | input | REG_W | Register written from memory by the execute instruction |
| exe_cond_ok | input | 1 | Branch condition evaluated in execute (1 = taken) |
| mem_op | input | 3 | Instruction class in the memory register |
| mem_stat | input | 2 | Status produced by the memory stage |
| wb_stat | input | 2 | Status in the write-back register |
| f_stall | output | 1 | Hold the fetch register |
| d_stall | output | 1 | Hold the decode register |
| w_stall | output | 1 | Hold the write-back register |
| d_bubble | output | 1 | Load a no-op into the decode register |
| e_bubble | output | 1 | Load a no-op into the execute register |
| m_bubble | output | 1 | Load a no-op into the memory register |
| cc_write_en | output | 1 | Condition codes may be written this cycle |

## Verification
The checker tests the exception rules on every input combination it sees: the memory bubble and write-back stall against the status codes, the condition-code enable against the execute class and both statuses, and the rule that the decode register is never both held and bubbled. It also checks the load/use and mispredict responses and the rule that a return only affects fetch and decode when no load/use conflict exists. Only the directed scenarios show the priority between simultaneous cases with concrete values. They also show the "no register" exclusion, return detection separately in each of the three stages, and the quiet response to a taken branch.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [2:0] {
    CLS_NOP    = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_RET    = 3'd3,
    CLS_BRANCH = 3'd4,
    CLS_STORE  = 3'd5,
    CLS_OTHER  = 3'd6
  } op_class_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_HALT  = 2'd1,
    ST_ADDR  = 2'd2,
    ST_INSTR = 2'd3
  } stat_e;

  localparam int unsigned CLS_W  = 3;
  localparam int unsigned STAT_W = 2;

endpackage

// File: rtl/hzd_load_use.sv
module hzd_load_use
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W   = 4,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC*REG_W-1:0] src_ids,
  input  logic [CLS_W-1:0]         exe_op,
  input  logic [REG_W-1:0]         ld_dst,
  output logic                     conflict
);
  localparam logic [REG_W-1:0] NO_REG = '1;

  logic [NUM_SRC-1:0] src_hit;
  logic               exe_loads;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign src_hit[i] = (src_ids[i*REG_W +: REG_W] == ld_dst);
  end

  assign exe_loads = (exe_op == CLS_LOAD) && (ld_dst != NO_REG);
  assign conflict  = exe_loads && (|src_hit);
endmodule

// File: rtl/hzd_flow.sv
module hzd_flow
  import hzd_pkg::*;
#(
  parameter int unsigned NUM_STG = 3
) (
  input  logic [NUM_STG*CLS_W-1:0] stage_ops,
  input  logic [CLS_W-1:0]         exe_op,
  input  logic                     cond_ok,
  output logic                     ret_pending,
  output logic                     ret_in_dec,
  output logic                     mispredict
);
  logic [NUM_STG-1:0] is_ret;

  for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
    assign is_ret[s] = (stage_ops[s*CLS_W +: CLS_W] == CLS_RET);
  end

  assign ret_pending = |is_ret;
  assign ret_in_dec  = is_ret[0];
  assign mispredict  = (exe_op == CLS_BRANCH) && !cond_ok;
endmodule

// File: rtl/hzd_excp.sv
module hzd_excp
  import hzd_pkg::*;
(
  input  logic [STAT_W-1:0] mem_stat,
  input  logic [STAT_W-1:0] wb_stat,
  input  logic [CLS_W-1:0]  exe_op,
  output logic              fault_late,
  output logic              fault_wb,
  output logic              cc_en
);
  logic mem_fault;

  assign mem_fault  = (mem_stat != ST_OK);
  assign fault_wb   = (wb_stat != ST_OK);
  assign fault_late = mem_fault || fault_wb;
  assign cc_en      = (exe_op == CLS_ALU) && !fault_late;
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W   = 4,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [2:0]               dec_op,
  input  logic [NUM_SRC*REG_W-1:0] dec_srcs,
  input  logic [2:0]               exe_op,
  input  logic [REG_W-1:0]         exe_ld_dst,
  input  logic                     exe_cond_ok,
  input  logic [2:0]               mem_op,
  input  logic [1:0]               mem_stat,
  input  logic [1:0]               wb_stat,
  output logic                     f_stall,
  output logic                     d_stall,
  output logic                     w_stall,
  output logic                     d_bubble,
  output logic                     e_bubble,
  output logic                     m_bubble,
  output logic                     cc_write_en
);
  localparam int unsigned NUM_STG = 3;

  logic lu_hit, ret_pend, ret_dec, mis, fault_late, fault_wb, cc_ok;

  hzd_load_use #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) lu_i (
    .src_ids (dec_srcs),
    .exe_op  (exe_op),
    .ld_dst  (exe_ld_dst),
    .conflict(lu_hit)
  );

  hzd_flow #(.NUM_STG(NUM_STG)) flow_i (
    .stage_ops  ({mem_op, exe_op, dec_op}),
    .exe_op     (exe_op),
    .cond_ok    (exe_cond_ok),
    .ret_pending(ret_pend),
    .ret_in_dec (ret_dec),
    .mispredict (mis)
  );

  hzd_excp excp_i (
    .mem_stat  (mem_stat),
    .wb_stat   (wb_stat),
    .exe_op    (exe_op),
    .fault_late(fault_late),
    .fault_wb  (fault_wb),
    .cc_en     (cc_ok)
  );

  // A load/use conflict overrides the return's decode bubble, and a
  // mispredict cancels a return waiting in decode.
  logic unused_ret_dec;
  assign unused_ret_dec = ret_dec;

  always_comb begin
    f_stall     = lu_hit || ret_pend;
    d_stall     = lu_hit;
    d_bubble    = mis || (ret_pend && !lu_hit);
    e_bubble    = mis || lu_hit;
    m_bubble    = fault_late;
    w_stall     = fault_wb;
    cc_write_en = cc_ok;
  end
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
  parameter int unsigned REG_W   = 4,
  parameter int unsigned NUM_SRC = 2
) (
  input logic [2:0]               dec_op,
  input logic [NUM_SRC*REG_W-1:0] dec_srcs,
  input logic [2:0]               exe_op,
  input logic [REG_W-1:0]         exe_ld_dst,
  input logic                     exe_cond_ok,
  input logic [2:0]               mem_op,
  input logic [1:0]               mem_stat,
  input logic [1:0]               wb_stat,
  input logic                     f_stall,
  input logic                     d_stall,
  input logic                     w_stall,
  input logic                     d_bubble,
  input logic                     e_bubble,
  input logic                     m_bubble,
  input logic                     cc_write_en
);
  logic lu_seen;
  logic ret_seen;

  always_comb begin
    lu_seen = 1'b0;
    for (int i = 0; i < int'(NUM_SRC); i++)
      if (dec_srcs[i*REG_W +: REG_W] == exe_ld_dst) lu_seen = 1'b1;
    lu_seen  = lu_seen && (exe_op == 3'd2) && (exe_ld_dst != '1);
    ret_seen = (dec_op == 3'd3) || (exe_op == 3'd3) || (mem_op == 3'd3);
  end

  always_comb begin
    p_load_use_r1: assert (!lu_seen || (f_stall && d_stall && e_bubble && !d_bubble))
      else $error("R1 load/use response wrong");
    p_return_r3: assert (!(ret_seen && !lu_seen && exe_op != 3'd4) ||
                         (f_stall && d_bubble && !d_stall && !e_bubble))
      else $error("R3 return response wrong");
    p_mispredict_r4: assert (!(exe_op == 3'd4 && !exe_cond_ok) || (d_bubble && e_bubble))
      else $error("R4 mispredict response wrong");
    p_mem_bubble_r7: assert (m_bubble == (mem_stat != 2'd0 || wb_stat != 2'd0))
      else $error("R7 memory bubble wrong");
    p_wb_stall_r8: assert (w_stall == (wb_stat != 2'd0))
      else $error("R8 write-back stall wrong");
    p_cc_gate_r9: assert (!cc_write_en || (exe_op == 3'd1 && mem_stat == 2'd0 && wb_stat == 2'd0))
      else $error("R9 condition-code enable wrong");
    p_dec_excl_r10: assert (!(d_stall && d_bubble))
      else $error("R10 decode stall and bubble together");
  end
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) chk_i (
  .dec_op(dec_op), .dec_srcs(dec_srcs), .exe_op(exe_op), .exe_ld_dst(exe_ld_dst),
  .exe_cond_ok(exe_cond_ok), .mem_op(mem_op), .mem_stat(mem_stat), .wb_stat(wb_stat),
  .f_stall(f_stall), .d_stall(d_stall), .w_stall(w_stall), .d_bubble(d_bubble),
  .e_bubble(e_bubble), .m_bubble(m_bubble), .cc_write_en(cc_write_en)
);

// File: tb/hzd_ctrl_tb_top.sv
module hzd_ctrl_tb_top;
  localparam int unsigned REG_W = 4;
  localparam int unsigned NSRC  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]            dec_op, exe_op, mem_op;
  logic [NSRC*REG_W-1:0] dec_srcs;
  logic [REG_W-1:0]      exe_ld_dst;
  logic                  exe_cond_ok;
  logic [1:0]            mem_stat, wb_stat;
  logic f_stall, d_stall, w_stall, d_bubble, e_bubble, m_bubble, cc_write_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hzd_ctrl #(.REG_W(REG_W), .NUM_SRC(NSRC)) dut_i (
    .dec_op(dec_op), .dec_srcs(dec_srcs), .exe_op(exe_op), .exe_ld_dst(exe_ld_dst),
    .exe_cond_ok(exe_cond_ok), .mem_op(mem_op), .mem_stat(mem_stat), .wb_stat(wb_stat),
    .f_stall(f_stall), .d_stall(d_stall), .w_stall(w_stall), .d_bubble(d_bubble),
    .e_bubble(e_bubble), .m_bubble(m_bubble), .cc_write_en(cc_write_en)
  );

  // Output vector order: f_stall d_stall w_stall d_bubble e_bubble m_bubble cc_write_en
  task automatic idle();
    @(negedge clk);
    dec_op = 3'd0; exe_op = 3'd0; mem_op = 3'd0; dec_srcs = '0;
    exe_ld_dst = '0; exe_cond_ok = 1'b0; mem_stat = 2'd0; wb_stat = 2'd0;
  endtask

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] act;
    #2;
    act = {f_stall, d_stall, w_stall, d_bubble, e_bubble, m_bubble, cc_write_en};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    idle(); check("R10 idle", 7'b0000000);
  endtask

  task automatic t_load_use();
    idle(); exe_op = 3'd2; exe_ld_dst = 4'd3; dec_srcs = {4'd15, 4'd3};
    check("R1 source 0 match", 7'b1100100);
    idle(); exe_op = 3'd2; exe_ld_dst = 4'd3; dec_srcs = {4'd3, 4'd15};
    check("R1 source 1 match", 7'b1100100);
  endtask

  task automatic t_no_conflict();
    idle(); exe_op = 3'd2; exe_ld_dst = 4'd3; dec_srcs = {4'd5, 4'd6};
    check("R2 no match", 7'b0000000);
    idle(); exe_op = 3'd2; exe_ld_dst = 4'd15; dec_srcs = {4'd15, 4'd15};
    check("R2 no-register code", 7'b0000000);
    idle(); exe_op = 3'd5; exe_ld_dst = 4'd3; dec_srcs = {4'd3, 4'd3};
    check("R2 non-load match", 7'b0000000);
  endtask

  task automatic t_return();
    idle(); dec_op = 3'd3; check("R3 return in decode", 7'b1001000);
    idle(); exe_op = 3'd3; check("R3 return in execute", 7'b1001000);
    idle(); mem_op = 3'd3; check("R3 return in memory", 7'b1001000);
  endtask

  task automatic t_branch();
    idle(); exe_op = 3'd4; exe_cond_ok = 1'b0; check("R4 mispredict", 7'b0001100);
    idle(); exe_op = 3'd4; exe_cond_ok = 1'b1; check("R4 taken branch", 7'b0000000);
  endtask

  task automatic t_mis_ret();
    idle(); exe_op = 3'd4; exe_cond_ok = 1'b0; dec_op = 3'd3;
    check("R5 mispredict with return", 7'b1001100);
  endtask

  task automatic t_lu_ret();
    idle(); dec_op = 3'd3; dec_srcs = {4'd15, 4'd7}; exe_op = 3'd2; exe_ld_dst = 4'd7;
    check("R6 load/use with return", 7'b1100100);
  endtask

  task automatic t_excp();
    idle(); mem_stat = 2'd2; exe_op = 3'd1; check("R7 memory fault", 7'b0000010);
    idle(); wb_stat = 2'd1; check("R8 write-back halt", 7'b0010010);
    idle(); wb_stat = 2'd3; mem_stat = 2'd2; check("R8 both faults", 7'b0010010);
  endtask

  task automatic t_setcc();
    idle(); exe_op = 3'd1; check("R9 ALU all normal", 7'b0000001);
    idle(); exe_op = 3'd1; wb_stat = 2'd2; check("R9 ALU write-back fault", 7'b0010010);
    idle(); exe_op = 3'd6; check("R9 non-ALU", 7'b0000000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_use();
    t_no_conflict();
    t_return();
    t_branch();
    t_mis_ret();
    t_lu_ret();
    t_excp();
    t_setcc();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule